// File: doc/BRIEF.md
# Device Interrupt Mapping Controller

This block sits between a set of interrupt-raising devices and the processors. Each device source has a routing entry that names a target CPU and an interrupt vector, and a control entry that holds a mask and a pending flag. A single-cycle strobe from an unmasked source becomes a posted interrupt: a one-cycle pulse on the post interface that carries the routed CPU number and vector. Taking an interrupt masks its source automatically, so software must unmask the source again before it can fire a second time.

Software programs the block through a simple request port made of valid, write, address and data signals. The routing entries sit in one address window and the control entries sit in another. Entries are eight bytes apart. When several sources are taken in the same cycle, they are posted one per cycle, lowest-numbered source first.

Top module: `irq_map_ctrl`

## Requirements
- R1: After reset, every source reads back mask=1 and pend=0, and its CPU and vector fields read back as zero.
- R2: A write to a routing entry loads the CPU number from data bits 12:8 and the vector from data bits 5:0. A read of that entry returns cpu<<8 | vector, with all other bits zero.
- R3: A strobe on a masked source is dropped. No post follows, and its mask and pend are unchanged.
- R4: A strobe on an unmasked source sets both its mask and its pend flags.
- R5: A taken strobe sampled at clock edge k gives post_valid high for exactly one cycle after edge k+1, carrying that source's routed CPU and vector, provided no lower-numbered source is waiting.
- R6: A control write loads mask from data bit 2. It clears pend only when data bit 1 is 1; with bit 1 at 0, pend keeps its value.
- R7: A control read returns mask in bit 2 and pend in bit 0, with all other bits zero.
- R8: The routing window starts at offset 0x000 and the control window at 0x100. Each window holds one 8-byte entry per source, and the source index is (offset - window base) >> 3, so address bits 2:0 do not matter.
- R9: Sources taken in the same cycle are posted on consecutive cycles in ascending source order, one post per cycle.
- R10: An access outside both windows has no effect on any state. It reads as zero and raises acc_err for exactly the one cycle in which its response appears.
- R11: Every read request gets rd_valid and rd_data in the cycle after the request, and those values reflect the state before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq | input | NUM_SRC | One strobe per device source |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | DATA_W | Read response data |
| acc_err | output | 1 | One-cycle pulse for an unmapped access |
| post_valid | output | 1 | One-cycle posted-interrupt pulse |
| post_cpu | output | 5 | Target CPU of the post |
| post_vec | output | 6 | Vector of the post |

## Verification
The assertions assume that reset is held for at least one clock and that a request is never made during reset, so every `$past` term they use refers to a cycle after reset. They also assume that each strobe is a single sample, with no meaning attached to how long it stays high. The stimulus drives all inputs on the falling edge. It keeps requests and strobes at zero during reset, and it draws addresses from the two windows and from the unmapped gaps between and beyond them. Write data for the control window often includes bit 1 and has bit 2 set or clear with equal chance, so sources are unmasked often enough for taken interrupts to occur.

// File: rtl/irq_map_pkg.sv
package irq_map_pkg;

    localparam int CPU_W       = 5;
    localparam int VEC_W       = 6;
    localparam int CPU_LSB     = 8;
    localparam int MASK_BIT    = 2;
    localparam int CLR_BIT     = 1;
    localparam int PEND_BIT    = 0;
    localparam int ENTRY_SHIFT = 3;
    localparam int FIELD_W     = 16;

    typedef struct packed {
        logic [CPU_W-1:0] cpu;
        logic [VEC_W-1:0] vec;
    } route_t;

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_ROUTE = 2'd1,
        RGN_CTRL  = 2'd2
    } region_e;

    function automatic route_t unpack_route(input logic [FIELD_W-1:0] d);
        route_t r;
        r.cpu = d[CPU_LSB +: CPU_W];
        r.vec = d[VEC_W-1:0];
        return r;
    endfunction

    function automatic logic [FIELD_W-1:0] pack_route(input route_t r);
        logic [FIELD_W-1:0] d;
        d = '0;
        d[CPU_LSB +: CPU_W] = r.cpu;
        d[VEC_W-1:0]        = r.vec;
        return d;
    endfunction

    function automatic logic [FIELD_W-1:0] pack_ctrl(input logic mask, input logic pend);
        logic [FIELD_W-1:0] d;
        d = '0;
        d[MASK_BIT] = mask;
        d[PEND_BIT] = pend;
        return d;
    endfunction

endpackage

// File: rtl/irq_map_decode.sv
module irq_map_decode
    import irq_map_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_SRC    = 8,
    parameter int ROUTE_BASE = 'h000,
    parameter int CTRL_BASE  = 'h100,
    parameter int IDX_W      = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);
    localparam int SPAN = NUM_SRC << ENTRY_SHIFT;
    localparam logic [ADDR_W-1:0] SPAN_A  = ADDR_W'(SPAN);
    localparam logic [ADDR_W-1:0] RBASE_A = ADDR_W'(ROUTE_BASE);
    localparam logic [ADDR_W-1:0] CBASE_A = ADDR_W'(CTRL_BASE);

    logic [ADDR_W-1:0] off_route;
    logic [ADDR_W-1:0] off_ctrl;
    logic              unused_bits;

    assign off_route   = addr - RBASE_A;
    assign off_ctrl    = addr - CBASE_A;
    assign unused_bits = &{1'b0, off_route[ENTRY_SHIFT-1:0], off_ctrl[ENTRY_SHIFT-1:0]};

    always_comb begin
        region = RGN_NONE;
        idx    = '0;
        if (addr >= RBASE_A && off_route < SPAN_A) begin
            region = RGN_ROUTE;
            idx    = off_route[ENTRY_SHIFT +: IDX_W];
        end else if (addr >= CBASE_A && off_ctrl < SPAN_A) begin
            region = RGN_CTRL;
            idx    = off_ctrl[ENTRY_SHIFT +: IDX_W];
        end
    end

    always_comb begin
        if (region != RGN_NONE)
            a_idx_range_r8: assert (int'(idx) < NUM_SRC);
    end

endmodule

// File: rtl/irq_map_src.sv
module irq_map_src
    import irq_map_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               dev_irq,
    input  logic               route_we,
    input  logic               ctrl_we,
    input  logic [FIELD_W-1:0] wdata,
    input  logic               grant,
    output route_t             route,
    output logic               mask,
    output logic               pend,
    output logic               queued
);
    logic take;
    logic unused_bits;

    assign take        = dev_irq & ~mask;
    assign unused_bits = &{1'b0, wdata[FIELD_W-1:CPU_LSB+CPU_W], wdata[CPU_LSB-1:VEC_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            route  <= '0;
            mask   <= 1'b1;
            pend   <= 1'b0;
            queued <= 1'b0;
        end else begin
            if (route_we)
                route <= unpack_route(wdata);
            if (take) begin
                mask <= 1'b1;
                pend <= 1'b1;
            end else if (ctrl_we) begin
                mask <= wdata[MASK_BIT];
                if (wdata[CLR_BIT])
                    pend <= 1'b0;
            end
            if (take)
                queued <= 1'b1;
            else if (grant)
                queued <= 1'b0;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask && !pend && !queued && route == '0));

    p_route_load_r2: assert property (@(posedge clk) disable iff (rst)
        route_we |=> route == unpack_route($past(wdata)));

    p_masked_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (dev_irq && mask && !ctrl_we) |=> ($stable(pend) && mask));

    p_take_flags_r4: assert property (@(posedge clk) disable iff (rst)
        (dev_irq && !mask) |=> (mask && pend && queued));

    p_pend_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && !wdata[CLR_BIT] && !take) |=> pend == $past(pend));

    p_mask_load_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && !take) |=> mask == $past(wdata[MASK_BIT]));

endmodule

// File: rtl/irq_map_arb.sv
module irq_map_arb
    import irq_map_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] queued,
    input  route_t             routes [NUM_SRC],
    output logic [NUM_SRC-1:0] grant,
    output logic               post_valid,
    output route_t             post_route
);
    logic [IDX_W-1:0] sel;
    logic             any;

    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (queued[i]) begin
                sel = IDX_W'(i);
                any = 1'b1;
            end
        end
        grant = '0;
        if (any)
            grant[sel] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            post_valid <= 1'b0;
            post_route <= '0;
        end else begin
            post_valid <= any;
            if (any)
                post_route <= routes[sel];
        end
    end

    p_one_grant_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_post_has_cause_r5: assert property (@(posedge clk) disable iff (rst)
        post_valid |-> $past(|queued));

    p_grant_drains_r9: assert property (@(posedge clk) disable iff (rst)
        (|queued) |=> post_valid);

endmodule

// File: rtl/irq_map_ctrl.sv
module irq_map_ctrl
    import irq_map_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int ROUTE_BASE = 'h000,
    parameter int CTRL_BASE  = 'h100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] dev_irq,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic               acc_err,
    output logic               post_valid,
    output logic [CPU_W-1:0]   post_cpu,
    output logic [VEC_W-1:0]   post_vec
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    region_e            region;
    logic [IDX_W-1:0]   idx;
    route_t             routes [NUM_SRC];
    logic [NUM_SRC-1:0] masks;
    logic [NUM_SRC-1:0] pends;
    logic [NUM_SRC-1:0] queued;
    logic [NUM_SRC-1:0] grant;
    route_t             post_route;
    logic [DATA_W-1:0]  rd_next;
    logic               wr_route;
    logic               wr_ctrl;
    logic               unused_bits;

    assign unused_bits = &{1'b0, req_wdata[DATA_W-1:FIELD_W]};
    assign wr_route    = req_valid && req_write && region == RGN_ROUTE;
    assign wr_ctrl     = req_valid && req_write && region == RGN_CTRL;

    irq_map_decode #(
        .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC),
        .ROUTE_BASE(ROUTE_BASE), .CTRL_BASE(CTRL_BASE), .IDX_W(IDX_W)
    ) decode_i (
        .addr(req_addr), .region(region), .idx(idx)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_map_src src_i (
            .clk(clk), .rst(rst),
            .dev_irq(dev_irq[g]),
            .route_we(wr_route && idx == IDX_W'(g)),
            .ctrl_we(wr_ctrl && idx == IDX_W'(g)),
            .wdata(req_wdata[FIELD_W-1:0]),
            .grant(grant[g]),
            .route(routes[g]),
            .mask(masks[g]),
            .pend(pends[g]),
            .queued(queued[g])
        );
    end

    irq_map_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) arb_i (
        .clk(clk), .rst(rst),
        .queued(queued), .routes(routes),
        .grant(grant), .post_valid(post_valid), .post_route(post_route)
    );

    assign post_cpu = post_route.cpu;
    assign post_vec = post_route.vec;

    always_comb begin
        case (region)
            RGN_ROUTE: rd_next = DATA_W'(pack_route(routes[idx]));
            RGN_CTRL:  rd_next = DATA_W'(pack_ctrl(masks[idx], pends[idx]));
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            acc_err  <= 1'b0;
        end else begin
            rd_valid <= req_valid && !req_write;
            rd_data  <= (req_valid && !req_write) ? rd_next : '0;
            acc_err  <= req_valid && region == RGN_NONE;
        end
    end

    p_err_cause_r10: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> $past(req_valid));

    p_err_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (acc_err && rd_valid) |-> rd_data == '0);

    p_rd_timing_r11: assert property (@(posedge clk) disable iff (rst)
        rd_valid == $past(req_valid && !req_write));

    p_rd_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_data[DATA_W-1:CPU_LSB+CPU_W] == '0);

endmodule

// File: tb/irq_map_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_map_ctrl_tb_top;
    localparam int NS = 8;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] dev_irq = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          acc_err;
    logic          post_valid;
    logic [4:0]    post_cpu;
    logic [5:0]    post_vec;

    always #10 clk = ~clk;

    irq_map_ctrl dut_i (
        .clk(clk), .rst(rst), .dev_irq(dev_irq),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err),
        .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec)
    );

    int checks = 0;
    int errors = 0;

    // Reference state built from the requirements
    logic       m_mask [NS];
    logic       m_pend [NS];
    logic       m_q    [NS];
    logic [4:0] m_cpu  [NS];
    logic [5:0] m_vec  [NS];
    logic       e_pv, e_rv, e_err;
    logic [4:0] e_cpu;
    logic [5:0] e_vec;
    logic [DW-1:0] e_rd;

    task automatic chk(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // R8: route window 0x000, control window 0x100, index = (off - base) >> 3
    function automatic int m_region(input logic [AW-1:0] a);
        if (a < 12'h040) return 1;
        if (a >= 12'h100 && a < 12'h140) return 2;
        return 0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            m_mask[i] = 1'b1; m_pend[i] = 1'b0; m_q[i] = 1'b0;
            m_cpu[i] = '0; m_vec[i] = '0;
        end
        e_pv = 0; e_rv = 0; e_err = 0; e_cpu = '0; e_vec = '0; e_rd = '0;
    endtask

    task automatic model_step();
        int rg;
        int ix;
        logic found;
        rg = m_region(req_addr);
        ix = int'(req_addr[5:3]);
        found = 1'b0;
        e_pv = 1'b0;
        for (int i = 0; i < NS; i++) begin
            if (!found && m_q[i]) begin
                found = 1'b1; e_pv = 1'b1;
                e_cpu = m_cpu[i]; e_vec = m_vec[i];
                m_q[i] = 1'b0;
            end
        end
        e_rv  = req_valid && !req_write;
        e_err = req_valid && rg == 0;
        e_rd  = '0;
        if (e_rv && rg == 1) e_rd = {19'd0, m_cpu[ix], 2'd0, m_vec[ix]};
        if (e_rv && rg == 2) e_rd = {29'd0, m_mask[ix], 1'b0, m_pend[ix]};
        for (int i = 0; i < NS; i++) begin
            if (dev_irq[i] && !m_mask[i]) begin
                m_mask[i] = 1'b1; m_pend[i] = 1'b1; m_q[i] = 1'b1;
            end else if (req_valid && req_write && rg == 2 && ix == i) begin
                m_mask[i] = req_wdata[2];
                if (req_wdata[1]) m_pend[i] = 1'b0;
            end
            if (req_valid && req_write && rg == 1 && ix == i) begin
                m_cpu[i] = req_wdata[12:8];
                m_vec[i] = req_wdata[5:0];
            end
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(tag, "post_valid R5", DW'(post_valid), DW'(e_pv));
        if (e_pv) begin
            chk(tag, "post_cpu R5", DW'(post_cpu), DW'(e_cpu));
            chk(tag, "post_vec R5", DW'(post_vec), DW'(e_vec));
        end
        chk(tag, "rd_valid R11", DW'(rd_valid), DW'(e_rv));
        if (e_rv) chk(tag, "rd_data R11", rd_data, e_rd);
        chk(tag, "acc_err R10", DW'(acc_err), DW'(e_err));
    endtask

    task automatic idle();
        dev_irq = '0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        tick(tag);
        idle();
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        req_valid = 1; req_write = 0; req_addr = a;
        tick(tag);
        chk(tag, "readback", rd_data, exp);
        idle();
    endtask

    task automatic do_irq(input logic [NS-1:0] v, input string tag);
        dev_irq = v;
        tick(tag);
        idle();
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset values
        do_read(12'h018, 32'h0, "R1");
        do_read(12'h118, 32'h4, "R1");
        // R2 field positions
        do_write(12'h010, 32'hFFFF_FFFF, "R2");
        do_read(12'h010, 32'h1F3F, "R2");
        // R8 low address bits ignored
        do_write(12'h01D, 32'h0A15, "R8");
        do_read(12'h018, 32'h0A15, "R8");
        do_read(12'h11F, 32'h4, "R8");
        // R3 masked strobe is dropped
        do_irq(8'h04, "R3");
        tick("R3");
        chk("R3", "no post", DW'(post_valid), 32'h0);
        do_read(12'h110, 32'h4, "R3");
        // R6 unmask
        do_write(12'h110, 32'h0, "R6");
        do_read(12'h110, 32'h0, "R6");
        // R4 and R5: taken strobe
        do_irq(8'h04, "R4");
        chk("R5", "no post yet", DW'(post_valid), 32'h0);
        tick("R5");
        chk("R5", "post valid", DW'(post_valid), 32'h1);
        chk("R5", "post cpu", DW'(post_cpu), 32'h1F);
        chk("R5", "post vec", DW'(post_vec), 32'h3F);
        tick("R5");
        chk("R5", "single pulse", DW'(post_valid), 32'h0);
        do_read(12'h110, 32'h5, "R4");
        // R6 pend clear rules
        do_write(12'h110, 32'h4, "R6");
        do_read(12'h110, 32'h5, "R6");
        do_write(12'h110, 32'h6, "R6");
        do_read(12'h110, 32'h4, "R6");
        do_write(12'h110, 32'h2, "R7");
        do_read(12'h110, 32'h0, "R7");
        // R9 simultaneous strobes
        do_write(12'h008, 32'h0301, "R9");
        do_write(12'h028, 32'h0705, "R9");
        do_write(12'h108, 32'h0, "R9");
        do_write(12'h128, 32'h0, "R9");
        do_irq(8'h22, "R9");
        tick("R9");
        chk("R9", "first vec", DW'(post_vec), 32'h01);
        tick("R9");
        chk("R9", "second vec", DW'(post_vec), 32'h05);
        chk("R9", "second cpu", DW'(post_cpu), 32'h07);
        // R10 unmapped accesses
        do_read(12'h080, 32'h0, "R10");
        chk("R10", "err pulse", DW'(acc_err), 32'h1);
        do_write(12'h0C0, 32'hFFFF_FFFF, "R10");
        do_write(12'h148, 32'h0, "R10");
        tick("R10");
        chk("R10", "err one cycle", DW'(acc_err), 32'h0);
        do_read(12'h000, 32'h0, "R10");
        do_read(12'h108, 32'h5, "R10");

        // Constrained random mix
        for (int n = 0; n < 4000; n++) begin
            int kind;
            int win;
            dev_irq = NS'($urandom & $urandom);
            kind = int'($urandom % 3);
            win  = int'($urandom % 5);
            if (kind != 0) begin
                req_valid = 1;
                req_write = (kind == 2);
                case (win)
                    0, 1: req_addr = AW'($urandom % 64);
                    2, 3: req_addr = AW'(12'h100 + $urandom % 64);
                    default: req_addr = ($urandom % 2 == 0) ? AW'(12'h040 + $urandom % 192)
                                                            : AW'(12'h140 + $urandom % 3776);
                endcase
                req_wdata = $urandom;
                if (win == 2 || win == 3) req_wdata[1] = ($urandom % 4 != 0);
            end
            tick("RND");
            idle();
        end
        repeat (10) tick("RND");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule